// File: doc/BRIEF.md
# Read Timing Calibration Sequencer

The sequencer searches for the input sampling delay a serial flash controller needs at each fast clock divide ratio. After a start pulse it asks an external checksum engine for a reference checksum at the slowest setting. It then walks the candidate divide ratios from slowest to fastest. For each ratio it sweeps delay settings and asks for a checksum of the same fixed flash region each time. A setting passes when the returned checksum equals the reference.

For every ratio that reaches a passing setting, the smallest working delay is packed into a 32-bit timing word, one nibble per ratio. Ratios that never pass raise a fail flag. The caller supplies an allow mask. A ratio whose output frequency would exceed the permitted maximum has its allow bit cleared, and the sequencer skips it.

The checksum engine sits outside the block. It sees a one-cycle request strobe and must hold no state of its own. The request carries the divisor code, the delay value and the region offset and length. The engine answers with a one-cycle response strobe and the checksum.

Top module: `rd_trim_calib`

## Requirements
- R1: While reset is high and after it is released, `done`, `req_valid`, `timing` and `fail_flags` are all zero.
- R2: The first request after `start` uses divisor code 0 (divide by 16) and delay 0. Every `req_valid` strobe lasts one cycle, and `req_div`/`req_dly` hold steady until the response arrives.
- R3: Ratios are visited in the order 5, 4, 3, 2, 1 with divisor codes 13, 6, 14, 7, 15. Bit r-1 of `ratio_allow` enables ratio r. A disabled ratio issues no request, and its nibble and fail flag stay zero.
- R4: The delay value is 4 bits. Bit 3 adds the fixed extra input delay, and bits [2:0] hold a cycle count from 0 to 5. A ratio's first request uses delay 8. When a try with bit 3 set fails, the next request uses the next count, again with bit 3 set.
- R5: When a try with bit 3 set passes, the same count is retried with bit 3 clear. If that retry passes, the search for the ratio ends and `timing[(r-1)*4 +: 4]` receives the count with bit 3 clear. If the retry fails, the next count is tried with bit 3 set.
- R6: If no pass is found by count 5, the ratio's nibble stays zero and `fail_flags[r-1]` is set.
- R7: `start` clears `timing` and `fail_flags`. Bits 31:20 of `timing` are always zero.
- R8: `done` is a one-cycle pulse after the last ratio. `timing` and `fail_flags` stay stable until the next `start`.
- R9: `req_ofs` is always 0x10000 and `req_len` is always 0x200. A try passes exactly when `rsp_csum` equals the reference checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (accepted when idle) |
| ratio_allow | input | 5 | Bit r-1 enables divide ratio r |
| req_valid | output | 1 | One-cycle checksum request strobe |
| req_div | output | 4 | Divisor code for the request |
| req_dly | output | 4 | Delay value for the request |
| req_ofs | output | 32 | Region start offset in the first chip-select window |
| req_len | output | 32 | Region length in bytes |
| rsp_valid | input | 1 | One-cycle checksum response strobe |
| rsp_csum | input | 32 | Returned checksum |
| done | output | 1 | One-cycle completion pulse |
| timing | output | 32 | Packed delay nibbles, one per ratio |
| fail_flags | output | 5 | Bit r-1 set when ratio r found no passing delay |

## Verification
The assertions assume the engine answers each request with exactly one `rsp_valid` strobe, only while a request is outstanding. They also assume `start` is pulsed only while the sequencer is idle. The bench's engine model follows both rules: it queues a single response one to four cycles after each strobe, and it raises `start` only after `done` has been seen. For each ratio, the model's pass or fail decision comes from per-ratio thresholds for the two delay variants. Because of this, the expected delay sequence, the request count and the packed result can all be computed independently.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REF_WAIT,
    S_PICK,
    S_TRY_WAIT,
    S_NEXT,
    S_DONE
  } cal_state_e;

  // Divisor code for divide ratio d (1..16): even (d-1) maps to 15-(d-1)/2,
  // odd (d-1) maps to 7-(d-1)/2; ratio 16 yields code 0.
  function automatic logic [3:0] div_code(input int unsigned ratio);
    int unsigned k;
    k = ratio - 1;
    if (k[0]) return 4'(7 - (k >> 1));
    else      return 4'(15 - (k >> 1));
  endfunction

endpackage

// File: rtl/rtc_ref.sv
module rtc_ref #(
  parameter int CSUM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CSUM_W-1:0] csum_in,
  output logic              match
);

  logic [CSUM_W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst)       ref_q <= '0;
    else if (load) ref_q <= csum_in;
  end

  assign match = (csum_in == ref_q);

  // R9
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ref_q));

endmodule

// File: rtl/rtc_pack.sv
module rtc_pack #(
  parameter int NUM_RATIO = 5,
  parameter int NIB_W     = 4,
  parameter int RES_W     = 32,
  localparam int IDX_W    = (NUM_RATIO > 1) ? $clog2(NUM_RATIO) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [NIB_W-1:0] wr_val,
  output logic [RES_W-1:0] timing
);

  localparam int USED_W = NUM_RATIO * NIB_W;

  for (genvar g = 0; g < NUM_RATIO; g++) begin : g_nib
    logic [NIB_W-1:0] nib_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        nib_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        nib_q <= wr_val;
    end
    assign timing[g*NIB_W +: NIB_W] = nib_q;
  end

  if (RES_W > USED_W) begin : g_pad
    assign timing[RES_W-1:USED_W] = '0;
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (timing == '0));

endmodule

// File: rtl/rd_trim_calib.sv
module rd_trim_calib
  import rtc_pkg::*;
#(
  parameter int NUM_RATIO  = 5,
  parameter int DLY_W      = 4,
  parameter int CYC_MAX    = 5,
  parameter int CSUM_W     = 32,
  parameter int RES_W      = 32,
  parameter int OFS_W      = 32,
  parameter logic [OFS_W-1:0] REGION_OFS = 32'h0001_0000,
  parameter logic [OFS_W-1:0] REGION_LEN = 32'h0000_0200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NUM_RATIO-1:0] ratio_allow,
  output logic                 req_valid,
  output logic [3:0]           req_div,
  output logic [DLY_W-1:0]     req_dly,
  output logic [OFS_W-1:0]     req_ofs,
  output logic [OFS_W-1:0]     req_len,
  input  logic                 rsp_valid,
  input  logic [CSUM_W-1:0]    rsp_csum,
  output logic                 done,
  output logic [RES_W-1:0]     timing,
  output logic [NUM_RATIO-1:0] fail_flags
);

  localparam int CNT_W = DLY_W - 1;
  localparam int IDX_W = (NUM_RATIO > 1) ? $clog2(NUM_RATIO) : 1;

  cal_state_e       st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cyc;
  logic             hi;
  logic             req_valid_q;
  logic [3:0]       req_div_q;
  logic [DLY_W-1:0] req_dly_q;
  logic             done_q;
  logic [NUM_RATIO-1:0] fail_q;
  logic             match;
  logic [3:0]       code_tab [NUM_RATIO];

  for (genvar g = 0; g < NUM_RATIO; g++) begin : g_code
    assign code_tab[g] = div_code(g + 1);
  end

  logic ref_load, pack_clr, pack_wr;
  assign ref_load = (st == S_REF_WAIT) && rsp_valid;
  assign pack_clr = (st == S_IDLE) && start;
  assign pack_wr  = (st == S_TRY_WAIT) && rsp_valid && !hi && match;

  rtc_ref #(.CSUM_W(CSUM_W)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .load    (ref_load),
    .csum_in (rsp_csum),
    .match   (match)
  );

  rtc_pack #(.NUM_RATIO(NUM_RATIO), .NIB_W(DLY_W), .RES_W(RES_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clr    (pack_clr),
    .wr_en  (pack_wr),
    .wr_idx (idx),
    .wr_val ({1'b0, cyc}),
    .timing (timing)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      idx         <= '0;
      cyc         <= '0;
      hi          <= 1'b0;
      req_valid_q <= 1'b0;
      req_div_q   <= '0;
      req_dly_q   <= '0;
      done_q      <= 1'b0;
      fail_q      <= '0;
    end else begin
      req_valid_q <= 1'b0;
      done_q      <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            fail_q      <= '0;
            req_valid_q <= 1'b1;
            req_div_q   <= '0;
            req_dly_q   <= '0;
            st          <= S_REF_WAIT;
          end
        end
        S_REF_WAIT: begin
          if (rsp_valid) begin
            idx <= IDX_W'(NUM_RATIO - 1);
            st  <= S_PICK;
          end
        end
        S_PICK: begin
          if (ratio_allow[idx]) begin
            cyc         <= '0;
            hi          <= 1'b1;
            req_valid_q <= 1'b1;
            req_div_q   <= code_tab[idx];
            req_dly_q   <= {1'b1, {CNT_W{1'b0}}};
            st          <= S_TRY_WAIT;
          end else begin
            st <= S_NEXT;
          end
        end
        S_TRY_WAIT: begin
          if (rsp_valid) begin
            if (hi && match) begin
              hi          <= 1'b0;
              req_valid_q <= 1'b1;
              req_dly_q   <= {1'b0, cyc};
            end else if (!hi && match) begin
              st <= S_NEXT;
            end else if (cyc == CNT_W'(CYC_MAX)) begin
              fail_q[idx] <= 1'b1;
              st          <= S_NEXT;
            end else begin
              cyc         <= cyc + 1'b1;
              hi          <= 1'b1;
              req_valid_q <= 1'b1;
              req_dly_q   <= {1'b1, cyc + 1'b1};
            end
          end
        end
        S_NEXT: begin
          if (idx == '0) begin
            st <= S_DONE;
          end else begin
            idx <= idx - 1'b1;
            st  <= S_PICK;
          end
        end
        S_DONE: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_valid  = req_valid_q;
  assign req_div    = req_div_q;
  assign req_dly    = req_dly_q;
  assign req_ofs    = REGION_OFS;
  assign req_len    = REGION_LEN;
  assign done       = done_q;
  assign fail_flags = fail_q;

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R2
  ref_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start) |=> (req_valid && req_div == 4'd0 && req_dly == '0));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_TRY_WAIT && !rsp_valid) |=> ($stable(req_div) && $stable(req_dly)));

  // R4
  dly_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_dly[CNT_W-1:0] <= CNT_W'(CYC_MAX)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start) |=> ($stable(timing) && $stable(fail_flags)));

endmodule

// File: tb/test_rd_trim_calib.sv
module test_rd_trim_calib;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  ratio_allow = '0;
  logic        req_valid;
  logic [3:0]  req_div;
  logic [3:0]  req_dly;
  logic [31:0] req_ofs, req_len;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_csum = '0;
  logic        done;
  logic [31:0] timing;
  logic [4:0]  fail_flags;

  always #4 clk = ~clk;

  rd_trim_calib i_rd_trim_calib (
    .clk(clk), .rst(rst), .start(start), .ratio_allow(ratio_allow),
    .req_valid(req_valid), .req_div(req_div), .req_dly(req_dly),
    .req_ofs(req_ofs), .req_len(req_len), .rsp_valid(rsp_valid),
    .rsp_csum(rsp_csum), .done(done), .timing(timing), .fail_flags(fail_flags)
  );

  int n_chk = 0;
  int n_bad = 0;
  int thr_hi [5];
  int thr_lo [5];
  logic [31:0] gold;

  // engine model state
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] pend_val;
  bit          ref_expect;
  int          cur_r;
  logic [3:0]  exp_next;
  int          nreq;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [3:0] c);
    case (c)
      4'd13: return 5;
      4'd6:  return 4;
      4'd14: return 3;
      4'd7:  return 2;
      4'd15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_cyc(input int r);
    int m;
    m = (thr_hi[r-1] > thr_lo[r-1]) ? thr_hi[r-1] : thr_lo[r-1];
    return (m <= 5) ? m : -1;
  endfunction

  function automatic logic [31:0] exp_timing();
    logic [31:0] t = '0;
    for (int r = 1; r <= 5; r++)
      if (ratio_allow[r-1] && exp_cyc(r) >= 0) t[(r-1)*4 +: 4] = 4'(exp_cyc(r));
    return t;
  endfunction

  function automatic logic [4:0] exp_fail();
    logic [4:0] f = '0;
    for (int r = 1; r <= 5; r++)
      if (ratio_allow[r-1] && exp_cyc(r) < 0) f[r-1] = 1'b1;
    return f;
  endfunction

  function automatic int exp_nreq();
    int n = 1;
    for (int r = 1; r <= 5; r++) begin
      if (ratio_allow[r-1]) begin
        for (int c = 0; c <= 5; c++) begin
          n++;
          if (c >= thr_hi[r-1]) begin
            n++;
            if (c >= thr_lo[r-1]) break;
          end
        end
      end
    end
    return n;
  endfunction

  // checksum engine model
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend) begin
        if (cnt <= 1) begin
          rsp_valid = 1'b1;
          rsp_csum  = pend_val;
          pend      = 0;
        end else cnt--;
      end
      if (req_valid && !rst) begin
        int r;
        bit p;
        nreq++;
        if (ref_expect) begin
          // R2: reference request at code 0, delay 0
          chk(req_div == 4'd0 && req_dly == 4'd0, "R2 reference request", {req_div, req_dly}, 32'h0);
          ref_expect = 0;
          pend_val   = gold;
        end else begin
          r = ratio_of(req_div);
          // R3: known code, allowed ratio, descending order
          chk(r != 0 && ratio_allow[r-1] && r <= cur_r, "R3 ratio order/code", 32'(req_div), 32'(cur_r));
          if (r != cur_r) begin
            cur_r    = r;
            exp_next = 4'd8;
          end
          // R4 R5: delay sequence
          chk(req_dly == exp_next, "R4/R5 delay step", 32'(req_dly), 32'(exp_next));
          if (r >= 1) begin
            if (req_dly[3]) p = (int'(req_dly[2:0]) >= thr_hi[r-1]);
            else            p = (int'(req_dly[2:0]) >= thr_lo[r-1]);
          end else p = 0;
          if (req_dly[3] && p) exp_next = {1'b0, req_dly[2:0]};
          else                 exp_next = {1'b1, req_dly[2:0] + 3'd1};
          pend_val = p ? gold : (gold ^ ($urandom | 32'd1));
        end
        pend = 1;
        cnt  = $urandom_range(1, 4);
      end
    end
  end

  task automatic run_case(input string name);
    int w;
    logic [31:0] t_snap;
    logic [4:0]  f_snap;
    ref_expect = 1;
    cur_r      = 6;
    nreq       = 0;
    gold       = $urandom;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: cleared by start
    chk(timing == 32'h0 && fail_flags == 5'h0, {"R7 clear on start ", name}, timing, 32'h0);
    w = 0;
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, {"R8 done reached ", name}, 32'(done), 32'h1);
    chk(timing == exp_timing(), {"R5 timing ", name}, timing, exp_timing());
    chk(fail_flags == exp_fail(), {"R6 fail flags ", name}, 32'(fail_flags), 32'(exp_fail()));
    chk(nreq == exp_nreq(), {"R3 request count ", name}, 32'(nreq), 32'(exp_nreq()));
    chk(timing[31:20] == 12'h0, {"R7 upper bits ", name}, timing, exp_timing());
    t_snap = timing;
    f_snap = fail_flags;
    @(negedge clk);
    chk(done == 1'b0, {"R8 done one cycle ", name}, 32'(done), 32'h0);
    repeat (4) @(negedge clk);
    chk(timing == t_snap && fail_flags == f_snap && !req_valid, {"R8 result hold ", name}, timing, t_snap);
  endtask

  task automatic set_thr(input int h, input int l);
    for (int i = 0; i < 5; i++) begin
      thr_hi[i] = h;
      thr_lo[i] = l;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(done == 0 && req_valid == 0 && timing == 0 && fail_flags == 0, "R1 during reset", timing, 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(done == 0 && req_valid == 0 && timing == 0 && fail_flags == 0, "R1 after reset", timing, 32'h0);
    // R9: fixed region
    chk(req_ofs == 32'h10000, "R9 region offset", req_ofs, 32'h10000);
    chk(req_len == 32'h200, "R9 region length", req_len, 32'h200);

    ratio_allow = 5'h1f; set_thr(0, 0);
    run_case("all pass at zero");
    ratio_allow = 5'h1f; set_thr(6, 6);
    run_case("all fail R6");
    ratio_allow = 5'h00; set_thr(0, 0);
    run_case("none allowed R3");
    ratio_allow = 5'h1f;
    thr_hi = '{0, 1, 2, 3, 5};
    thr_lo = '{2, 1, 0, 3, 5};
    run_case("mixed thresholds");
    ratio_allow = 5'b10101; set_thr(5, 0);
    run_case("hi needs max count");
    ratio_allow = 5'b01010; set_thr(0, 6);
    run_case("lo never passes");

    for (int k = 0; k < 30; k++) begin
      ratio_allow = 5'($urandom);
      for (int i = 0; i < 5; i++) begin
        thr_hi[i] = $urandom_range(0, 6);
        thr_lo[i] = $urandom_range(0, 6);
      end
      run_case("random");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule